// File: doc/BRIEF.md
# Multi-Lane Pixel Word Serializer

This block turns one parallel pixel word (24 colour bits plus vertical sync, horizontal sync and data-enable) into a 30-bit frame and shifts that frame out over one, two or three serial lanes. The frame carries the 27 payload bits, two reserved bits that are always zero, and an odd-parity bit. A two-bit lane select picks how the frame is split: one lane with 30 bit slots, two lanes with 15 slots each, or three lanes with 10 slots each.

Everything runs on a single fast bit clock that is supplied from outside. Its rate must be 30, 15 or 10 times the pixel rate, to match the lane count. The pixel clock enters as a plain input. It is synchronized, and its rising or falling edge (chosen by a polarity input) captures the parallel word into a holding register. The block divides the bit clock by the frame length to recreate a pixel-rate clock output. It also drives a per-lane enable flag, so the unused lane drivers can be turned off. A swap input reverses the whole colour bus, which lets a board route it in either order.

Top module: `pws_serializer`

## Requirements
- R1: Frame layout. Bits 7:0 carry blue, bits 15:8 carry green and bits 23:16 carry red, each with colour bit 0 at the lowest position. Bit 24 is vsync, bit 25 is hsync and bit 26 is den. Bits 27 and 28 are always 0.
- R2: Frame bit 29 is 1 when frame bits 26:0 hold an even number of ones, and 0 otherwise. The reserved bits take no part in this.
- R3: Lane select. `link_sel` = 2'b00 gives one lane of 30 slots, 2'b01 gives two lanes of 15 slots, and 2'b10 gives three lanes of 10 slots. The code 2'b11 behaves exactly like 2'b10.
- R4: With N active lanes, frame bit k is sent on `lane_dat[k mod N]` in slot k div N. Slot 0 appears in the cycle in which `clk_out` rises, and each later slot follows one bit-clock cycle after the one before it.
- R5: `lane_en[i]` is 1 exactly when lane i is below the active lane count. A disabled lane holds `lane_dat[i]` at 0.
- R6: `clk_out` has a period of 30/N bit-clock cycles. It is high for floor((30/N)/2) cycles, starting with slot 0, and low for the rest of the period.
- R7: With `bus_swap` = 0, `pix_bus[23:16]` is red[7:0], `pix_bus[15:8]` is green[7:0] and `pix_bus[7:0]` is blue[7:0]. With `bus_swap` = 1, `pix_bus[i]` carries colour-word bit 23-i. The swap never reorders vsync, hsync or den.
- R8: With `cap_pol` = 0, a rising edge of `pix_clk` captures the word. With `cap_pol` = 1, a falling edge captures it. The other edge leaves the held word unchanged.
- R9: `link_sel` is sampled only at a frame boundary. A change in the middle of a frame leaves the current frame's length and lane count unchanged, and the new mode starts with the next frame. Each frame carries the word held at its start.
- R10: While `rst` is high, `clk_out`, `lane_en` and `lane_dat` are 0. The first frame begins in the first cycle after reset is released and carries an all-zero payload with parity 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (30, 15 or 10 times the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| cap_pol | input | 1 | 0: capture on the rising pixel edge, 1: capture on the falling edge |
| bus_swap | input | 1 | 1: colour bus fully bit-reversed |
| link_sel | input | 2 | Lane count select |
| pix_bus | input | 24 | Parallel colour input |
| vsync | input | 1 | Vertical sync |
| hsync | input | 1 | Horizontal sync |
| den | input | 1 | Data enable |
| clk_out | output | 1 | Recreated pixel-rate clock |
| lane_en | output | 3 | Per-lane driver enable |
| lane_dat | output | 3 | Serial lane data |

## Verification
Each frame is deserialized from the lanes with the expected lane count and reassembled. The result is then compared with a frame built from the requirement layout. Words with zero, one, two and 27 payload ones separate correct parity from inverted or even parity. Distinct, asymmetric colour values sent in every lane code expose wrong lane interleaving, wrong slot order and wrong handling of the reserved code. The same values sent through the swapped bus, and edges of the unselected polarity, show whether bus reversal and edge selection are applied. A mid-frame lane-select change, timed by counting cycles to the next clock rise, shows whether the mode is taken only at frame boundaries.

// File: rtl/pws_pkg.sv
package pws_pkg;

  localparam int unsigned COLOR_BITS = 24;
  localparam int unsigned SYNC_BITS  = 3;
  localparam int unsigned RSV_BITS   = 2;
  localparam int unsigned MAX_LANES  = 3;

  typedef enum logic [1:0] {
    LM_ONE   = 2'd0,
    LM_TWO   = 2'd1,
    LM_THREE = 2'd2
  } lane_mode_t;

  // The reserved code maps onto three lanes (R3)
  function automatic lane_mode_t decode_sel(input logic [1:0] sel);
    case (sel)
      2'b00:   return LM_ONE;
      2'b01:   return LM_TWO;
      default: return LM_THREE;
    endcase
  endfunction

  function automatic int unsigned lane_count(input lane_mode_t m);
    case (m)
      LM_ONE:  return 1;
      LM_TWO:  return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [MAX_LANES-1:0] lane_mask(input lane_mode_t m);
    logic [MAX_LANES-1:0] mask;
    for (int i = 0; i < int'(MAX_LANES); i++)
      mask[i] = (i < int'(lane_count(m)));
    return mask;
  endfunction

endpackage

// File: rtl/pws_capture.sv
module pws_capture
  import pws_pkg::*;
#(
  parameter int unsigned COLOR_W     = COLOR_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pix_clk,
  input  logic                         cap_pol,
  input  logic                         bus_swap,
  input  logic [COLOR_W-1:0]           pix_bus,
  input  logic                         vsync,
  input  logic                         hsync,
  input  logic                         den,
  output logic [COLOR_W+SYNC_BITS-1:0] word_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lvl;
  logic                   take;
  logic [COLOR_W-1:0]     color;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pix_clk};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  // R8: only the selected edge captures
  assign take = cap_pol ? (!lvl && last_q) : (lvl && !last_q);

  // R7: full reversal of the colour bus
  for (genvar i = 0; i < COLOR_W; i++) begin : g_swap
    assign color[i] = bus_swap ? pix_bus[COLOR_W-1-i] : pix_bus[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (take)
      word_q <= {den, hsync, vsync, color};
  end

endmodule

// File: rtl/pws_timebase.sv
module pws_timebase
  import pws_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned LANES   = MAX_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       link_sel,
  output logic             load,
  output lane_mode_t       mode_n,
  output logic             clk_out,
  output logic [LANES-1:0] lane_en
);

  localparam int unsigned PH_W = $clog2(FRAME_W);

  function automatic logic [PH_W-1:0] ratio_of(input lane_mode_t m);
    return PH_W'(FRAME_W / lane_count(m));
  endfunction

  logic [PH_W-1:0] ph_q;
  lane_mode_t      mode_q;
  logic [PH_W-1:0] ratio;
  logic [PH_W-1:0] half;
  logic [PH_W-1:0] ph_inc;

  assign ratio  = ratio_of(mode_q);
  assign half   = ratio >> 1;
  assign ph_inc = ph_q + 1'b1;
  assign load   = (ph_q == ratio - 1'b1);
  assign mode_n = decode_sel(link_sel);

  // R9: mode taken only at the frame boundary; R6: clock shape
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_W'(FRAME_W - 1);
      mode_q  <= LM_ONE;
      clk_out <= 1'b0;
      lane_en <= '0;
    end else if (load) begin
      ph_q    <= '0;
      mode_q  <= mode_n;
      clk_out <= 1'b1;
      lane_en <= LANES'(lane_mask(mode_n));
    end else begin
      ph_q    <= ph_inc;
      clk_out <= (ph_inc < half);
    end
  end

endmodule

// File: rtl/pws_lanes.sv
module pws_lanes
  import pws_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned LANES   = MAX_LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  lane_mode_t         mode_n,
  input  logic [FRAME_W-1:0] frame,
  output logic [LANES-1:0]   lane_dat
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANES-1:0][FRAME_W-1:0] cand;
    logic [FRAME_W-1:0]            ld;
    logic [FRAME_W-1:0]            sr_q;

    // R4: slot s of lane g holds frame bit s*N+g for every lane count N
    for (genvar m = 0; m < LANES; m++) begin : g_mode
      for (genvar s = 0; s < FRAME_W; s++) begin : g_slot
        if ((g < m + 1) && (s * (m + 1) + g < FRAME_W)) begin : g_used
          assign cand[m][s] = frame[s * (m + 1) + g];
        end else begin : g_zero
          assign cand[m][s] = 1'b0;
        end
      end
    end

    always_comb begin
      case (mode_n)
        LM_ONE:  ld = cand[0];
        LM_TWO:  ld = cand[1];
        default: ld = cand[LANES-1];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)
        sr_q <= '0;
      else if (load)
        sr_q <= ld;
      else
        sr_q <= {1'b0, sr_q[FRAME_W-1:1]};
    end

    assign lane_dat[g] = sr_q[0];
  end

endmodule

// File: rtl/pws_serializer.sv
module pws_serializer
  import pws_pkg::*;
#(
  parameter int unsigned COLOR_W     = COLOR_BITS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LANES       = MAX_LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_clk,
  input  logic               cap_pol,
  input  logic               bus_swap,
  input  logic [1:0]         link_sel,
  input  logic [COLOR_W-1:0] pix_bus,
  input  logic               vsync,
  input  logic               hsync,
  input  logic               den,
  output logic               clk_out,
  output logic [LANES-1:0]   lane_en,
  output logic [LANES-1:0]   lane_dat
);

  localparam int unsigned PAY_W   = COLOR_W + SYNC_BITS;
  localparam int unsigned FRAME_W = PAY_W + RSV_BITS + 1;

  logic [PAY_W-1:0]   word_q;
  logic [FRAME_W-1:0] frame;
  logic               load;
  lane_mode_t         mode_n;

  pws_capture #(
    .COLOR_W    (COLOR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_capture (
    .clk     (clk),
    .rst     (rst),
    .pix_clk (pix_clk),
    .cap_pol (cap_pol),
    .bus_swap(bus_swap),
    .pix_bus (pix_bus),
    .vsync   (vsync),
    .hsync   (hsync),
    .den     (den),
    .word_q  (word_q)
  );

  // R1/R2: reserved zeros and odd parity over the payload only
  assign frame = {~^word_q, {RSV_BITS{1'b0}}, word_q};

  pws_timebase #(
    .FRAME_W(FRAME_W),
    .LANES  (LANES)
  ) i_timebase (
    .clk     (clk),
    .rst     (rst),
    .link_sel(link_sel),
    .load    (load),
    .mode_n  (mode_n),
    .clk_out (clk_out),
    .lane_en (lane_en)
  );

  pws_lanes #(
    .FRAME_W(FRAME_W),
    .LANES  (LANES)
  ) i_lanes (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .mode_n  (mode_n),
    .frame   (frame),
    .lane_dat(lane_dat)
  );

endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned LANES   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_out,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] lane_dat
);

  logic       clk_prev;
  logic       rose;
  logic [7:0] cnt;
  logic       acc;
  logic       seen;
  int         n_act;
  logic [LANES-1:0] rsv;

  assign rose = clk_out && !clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      cnt      <= '0;
      acc      <= 1'b0;
      seen     <= 1'b0;
    end else begin
      clk_prev <= clk_out;
      cnt      <= rose ? 8'd1 : cnt + 8'd1;
      acc      <= (rose ? 1'b0 : acc) ^ lane_dat[0];
      if (rose) seen <= 1'b1;
    end
  end

  always_comb begin
    n_act = $countones(lane_en);
    for (int l = 0; l < int'(LANES); l++) begin
      int idx;
      idx    = int'(cnt) * n_act + l;
      rsv[l] = (l < n_act) && (idx == int'(FRAME_W) - 3 || idx == int'(FRAME_W) - 2);
    end
  end

  AST_EN_CONTIG: assert property (@(posedge clk) disable iff (rst)
    lane_en[2] |-> lane_en[1] && lane_en[0]);  // R5

  AST_EN_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !rose |-> $stable(lane_en));  // R9

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    (rose && seen) |-> (int'(cnt) == int'(FRAME_W) / $countones($past(lane_en))));  // R6

  AST_CLK_HALF: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out) |-> (int'(cnt) == (int'(FRAME_W) / n_act) / 2));  // R6

  AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
    (rose && seen && $past(lane_en) == LANES'(1)) |-> acc);  // R2

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    AST_IDLE_LANE_LOW: assert property (@(posedge clk) disable iff (rst)
      !lane_en[l] |-> !lane_dat[l]);  // R5

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!rose && rsv[l]) |-> !lane_dat[l]);  // R1
  end

endmodule

bind pws_serializer pws_checker #(
  .FRAME_W(FRAME_W),
  .LANES  (LANES)
) i_pws_checker (
  .clk     (clk),
  .rst     (rst),
  .clk_out (clk_out),
  .lane_en (lane_en),
  .lane_dat(lane_dat)
);

// File: tb/test_pws_serializer.sv
`timescale 1ns/1ps
module test_pws_serializer;

  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_clk = 1'b0;
  logic        cap_pol = 1'b0;
  logic        bus_swap = 1'b0;
  logic [1:0]  link_sel = 2'b00;
  logic [23:0] pix_bus = '0;
  logic        vsync = 1'b0, hsync = 1'b0, den = 1'b0;
  logic        clk_out;
  logic [2:0]  lane_en;
  logic [2:0]  lane_dat;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  pws_serializer i_pws_serializer (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .cap_pol(cap_pol),
    .bus_swap(bus_swap), .link_sel(link_sel), .pix_bus(pix_bus),
    .vsync(vsync), .hsync(hsync), .den(den),
    .clk_out(clk_out), .lane_en(lane_en), .lane_dat(lane_dat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_for(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 3;
  endfunction

  function automatic logic [29:0] exp_frame(input logic [7:0] r, g, b, input logic vs, hs, de);
    logic [26:0] p;
    p = {de, hs, vs, r, g, b};
    return {~^p, 2'b00, p};
  endfunction

  task automatic wait_start();
    logic p;
    p = clk_out;
    forever begin
      @(negedge clk);
      if (clk_out && !p) break;
      p = clk_out;
    end
  endtask

  task automatic grab(input int n, output logic [29:0] fr, output logic [2:0] en,
                      output int idle_bad, output int clk_bad);
    int r;
    r = 30 / n;
    fr = '0; idle_bad = 0; clk_bad = 0;
    wait_start();
    en = lane_en;
    for (int s = 0; s < r; s++) begin
      if (s > 0) @(negedge clk);
      for (int l = 0; l < 3; l++) begin
        if (l < n) fr[s*n+l] = lane_dat[l];
        else if (lane_dat[l] !== 1'b0) idle_bad++;
      end
      if (clk_out !== (s < r/2)) clk_bad++;
    end
  endtask

  task automatic check_frame(input logic [1:0] code, input logic [29:0] exp, input string tag);
    logic [29:0] fr;
    logic [2:0]  en, mask;
    int          n, ib, cb;
    n = lanes_for(code);
    mask = (n == 1) ? 3'b001 : (n == 2) ? 3'b011 : 3'b111;
    grab(n, fr, en, ib, cb);
    chk(fr === exp, {tag, " R4 reassembled frame"}, fr, exp);
    chk(en === mask, {tag, " R5 lane enables"}, en, mask);
    chk(ib == 0, {tag, " R5 idle lanes low"}, ib, 0);
    chk(cb == 0, {tag, " R6 clock shape"}, cb, 0);
  endtask

  task automatic send(input logic [1:0] code, input logic [7:0] r, g, b,
                      input logic vs, hs, de, input string tag);
    logic [23:0] c;
    c = {r, g, b};
    link_sel = code;
    wait_start();
    pix_bus = bus_swap ? {<<{c}} : c;
    vsync = vs; hsync = hs; den = de;
    pix_clk = cap_pol;
    repeat (2) @(negedge clk);
    pix_clk = ~cap_pol;
    @(negedge clk);
    check_frame(code, exp_frame(r, g, b, vs, hs, de), tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(clk_out === 1'b0, "R10 clk_out in reset", clk_out, 0);
    chk(lane_en === 3'b000, "R10 lane_en in reset", lane_en, 0);
    chk(lane_dat === 3'b000, "R10 lane_dat in reset", lane_dat, 0);
    rst = 1'b0;
    check_frame(2'b00, 30'h2000_0000, "R10 first frame");
  endtask

  task automatic t_modes();
    send(2'b00, 8'hA5, 8'h3C, 8'h81, 1'b1, 1'b0, 1'b1, "R3 one lane R1");
    send(2'b01, 8'h12, 8'hF0, 8'h6E, 1'b0, 1'b1, 1'b1, "R3 two lanes R1");
    send(2'b10, 8'hC3, 8'h07, 8'h5A, 1'b1, 1'b1, 1'b0, "R3 three lanes R1");
    send(2'b11, 8'h39, 8'hE4, 8'h1B, 1'b0, 1'b0, 1'b1, "R3 reserved code");
  endtask

  task automatic t_parity();
    send(2'b00, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R2 all ones");
    send(2'b01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R2 all zeros");
    send(2'b10, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, "R2 single one");
    send(2'b10, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, "R2 two ones");
  endtask

  task automatic t_swap();
    bus_swap = 1'b1;
    send(2'b00, 8'hA5, 8'h3C, 8'h81, 1'b1, 1'b0, 1'b0, "R7 swap one lane");
    send(2'b10, 8'h01, 8'h80, 8'hF3, 1'b0, 1'b1, 1'b1, "R7 swap three lanes");
    bus_swap = 1'b0;
  endtask

  task automatic t_polarity();
    logic [29:0] held;
    cap_pol = 1'b1;
    send(2'b01, 8'h5C, 8'h21, 8'h9E, 1'b1, 1'b0, 1'b1, "R8 falling edge");
    held = exp_frame(8'h5C, 8'h21, 8'h9E, 1'b1, 1'b0, 1'b1);
    wait_start();
    pix_bus = 24'h0F0F0F; vsync = 1'b0; hsync = 1'b1; den = 1'b0;
    pix_clk = 1'b1;
    repeat (3) @(negedge clk);
    check_frame(2'b01, held, "R8 rising edge ignored");
    cap_pol = 1'b0;
    send(2'b00, 8'hE1, 8'h1E, 8'h77, 1'b0, 1'b1, 1'b0, "R8 rising edge");
  endtask

  task automatic t_switch();
    int  cnt;
    logic p;
    link_sel = 2'b00;
    wait_start();
    wait_start();
    repeat (3) @(negedge clk);
    link_sel = 2'b10;
    cnt = 0;
    p = clk_out;
    forever begin
      @(negedge clk);
      cnt++;
      if (clk_out && !p) break;
      p = clk_out;
    end
    chk(cnt == 27, "R9 frame kept its length after mid-frame select change", cnt, 27);
    chk(lane_en === 3'b111, "R9 new lane count at boundary", lane_en, 3'b111);
    check_frame(2'b10, exp_frame(8'hE1, 8'h1E, 8'h77, 1'b0, 1'b1, 1'b0), "R9 held word resent");
  endtask

  initial begin
    t_reset();
    t_modes();
    t_parity();
    t_swap();
    t_polarity();
    t_switch();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule